// File: doc/BRIEF.md
# Dual Cascadable Interval Timer with Toggle Output

The block holds two 8-bit down-counters, timer 0 and timer 1. Each one counts qualifying count clocks and reloads its programmed start value when it wraps past zero. At each wrap it raises a one-cycle underflow strobe. The two counters can run on their own, or they can be chained into a single 16-bit counter. When chained, timer 0 is the low byte and timer 1 is the high byte.

A count clock is a prescaled tick input. In pulse-width measurement mode, the tick is also qualified by the level of an external event input. A toggle output flips on every underflow of a selected channel, which gives a clock at half the underflow rate. A complementary copy of it is driven on a second pin when a build-time option is set.

Software programs the block through a small write port with three locations: reload value 0, reload value 1, and a control byte. Each channel is run by a two-state controller:

- IDLE: the counter tracks its reload value. The transition IDLE→COUNT is taken when the run bit is set.
- COUNT: the counter decrements on count clocks. The transition COUNT→IDLE is taken when the run bit is cleared.

Top module: `cascade_timer`

## Requirements
- R1: After reset, uf0, uf1 and tout are 0 and tout_n is 1, with INV_OUT=1.
- R2: Write map and control encoding:
  - Address 0 sets reload value 0, and address 1 sets reload value 1.
  - Address 2 sets the control byte: bit0 run0, bit1 run1, bit2 cascade, bit3 gate0, bit4 gate1, bit5 chsel, bit6 out_en.
  - With cascade=0 and a tick on every cycle, timer n with reload value R strobes its underflow once every R+1 cycles. When R=0 the strobe stays high.
- R3: While its run bit is 0, a timer produces no underflow and holds its reload value. After run is set by a write, the first strobe of timer 0 is registered at the (R+2)th clock edge after the write edge.
- R4: With the gate bit set, a count clock is accepted only while evt_in equals EVT_ACTIVE (1 by default). With the event held inactive there is no underflow. With the event alternating every cycle, the period doubles.
- R5: With cascade=1, timer 1 steps only on timer 0 wraps and is governed by run0. uf1 repeats every (R0+1)*(R1+1) count clocks, and uf0 stays 0.
- R6: The toggle output flips on each underflow of the selected channel: chsel=0 selects timer 0 and chsel=1 selects timer 1. Its period is twice the underflow period.
- R7: With cascade=1, tout follows the 16-bit underflow whatever the value of chsel.
- R8: Changing chsel while running causes no toggle at the switch. The next toggle comes from the newly selected channel.
- R9: While out_en is 0, tout is held at 0.
- R10: With INV_OUT=1, tout_n is always the complement of tout. With INV_OUT=0, tout_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| tick0 | input | 1 | Prescaled count enable for timer 0 |
| tick1 | input | 1 | Prescaled count enable for timer 1 |
| evt_in | input | 1 | Event level used to gate counting |
| uf0 | output | 1 | Timer 0 underflow strobe |
| uf1 | output | 1 | Timer 1 (or 16-bit) underflow strobe |
| tout | output | 1 | Toggle output |
| tout_n | output | 1 | Inverted toggle output (build option) |

## Verification
The hardest case to reach from the ports is a channel switch that lands while the newly selected timer is far from its wrap, because only then can a spurious toggle at the switch be told apart from a real one. The bench starts both timers together, with a short reload on timer 0 and a long reload on timer 1. It lets timer 0 drive several toggles, then moves chsel to timer 1 well before timer 1's first wrap. It then checks that tout stays frozen through that gap and flips once timer 1 wraps.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_RLD0 = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_RLD1 = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
    localparam int unsigned CTRL_W = 7;

    // MSB first: bit6 out_en ... bit0 run0
    typedef struct packed {
        logic out_en;
        logic chsel;
        logic gate1;
        logic gate0;
        logic cascade;
        logic run1;
        logic run0;
    } ctrl_t;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    output logic [CNT_W-1:0]       rld0,
    output logic [CNT_W-1:0]       rld1,
    output ctrl_t                  ctrl
);
    logic unused_hi;
    assign unused_hi = ^wr_data[CNT_W-1:CTRL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld0 <= '0;
            rld1 <= '0;
            ctrl <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_RLD0: rld0 <= wr_data;
                ADR_RLD1: rld1 <= wr_data;
                ADR_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/ctmr_chan.sv
module ctmr_chan
    import ctmr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic             wrap
);
    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             active;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (run)  st_d = CH_COUNT;
            CH_COUNT: if (!run) st_d = CH_IDLE;
            default:  st_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active = (st_q == CH_COUNT) && run;
        wrap   = active && step && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!active) cnt_q <= reload;
        else if (step)   cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
endmodule

// File: rtl/ctmr_out.sv
module ctmr_out #(
    parameter bit INV_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap0,
    input  logic wrap1,
    input  logic cascade,
    input  logic chsel,
    input  logic out_en,
    output logic uf0,
    output logic uf1,
    output logic tout,
    output logic tout_n
);
    logic sel_wrap;
    logic tgl_q;

    always_comb sel_wrap = (cascade || chsel) ? wrap1 : wrap0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf0   <= 1'b0;
            uf1   <= 1'b0;
            tgl_q <= 1'b0;
        end else begin
            uf0 <= wrap0 && !cascade;
            uf1 <= wrap1;
            if (!out_en)       tgl_q <= 1'b0;
            else if (sel_wrap) tgl_q <= ~tgl_q;
        end
    end

    assign tout = tgl_q;

    generate
        if (INV_OUT) begin : g_inv
            assign tout_n = ~tgl_q;
        end else begin : g_noinv
            assign tout_n = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter bit          EVT_ACTIVE = 1'b1,
    parameter bit          INV_OUT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick0,
    input  logic              tick1,
    input  logic              evt_in,
    output logic              uf0,
    output logic              uf1,
    output logic              tout,
    output logic              tout_n
);
    logic [CNT_W-1:0] rld0, rld1;
    ctrl_t            ctrl_q;
    logic             evt_on, step0, step1, run1_eff, wrap0, wrap1;

    ctmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rld0(rld0), .rld1(rld1), .ctrl(ctrl_q)
    );

    always_comb begin
        evt_on   = (evt_in == EVT_ACTIVE);
        step0    = tick0 && (!ctrl_q.gate0 || evt_on);
        step1    = ctrl_q.cascade ? wrap0 : (tick1 && (!ctrl_q.gate1 || evt_on));
        run1_eff = ctrl_q.cascade ? ctrl_q.run0 : ctrl_q.run1;
    end

    ctmr_chan #(.CNT_W(CNT_W)) u_ch0 (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run0), .step(step0),
        .reload(rld0), .wrap(wrap0)
    );

    ctmr_chan #(.CNT_W(CNT_W)) u_ch1 (
        .clk(clk), .rst_n(rst_n), .run(run1_eff), .step(step1),
        .reload(rld1), .wrap(wrap1)
    );

    ctmr_out #(.INV_OUT(INV_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .wrap0(wrap0), .wrap1(wrap1),
        .cascade(ctrl_q.cascade), .chsel(ctrl_q.chsel), .out_en(ctrl_q.out_en),
        .uf0(uf0), .uf1(uf1), .tout(tout), .tout_n(tout_n)
    );
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter bit EVT_ACTIVE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic run0,
    input logic run1,
    input logic cascade,
    input logic gate0,
    input logic out_en,
    input logic evt_in,
    input logic uf0,
    input logic uf1,
    input logic tout
);
    // R3: a stopped timer 0 never strobes
    a_r3_stop0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run0 |=> !uf0);
    // R3: a stopped timer 1 in split mode never strobes
    a_r3_stop1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade && !run1) |=> !uf1);
    // R4: inactive event blocks counting in gated mode
    a_r4_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (gate0 && (evt_in != EVT_ACTIVE)) |=> !uf0);
    // R5: low byte strobe suppressed when chained
    a_r5_no_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> !uf0);
    // R6: tout only rises together with an underflow
    a_r6_rise_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout) |-> (uf0 || uf1));
    // R9: disabled output is held low
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !tout);
endmodule

bind cascade_timer ctmr_chk #(.EVT_ACTIVE(EVT_ACTIVE)) u_chk (
    .clk(clk), .rst_n(rst_n), .run0(ctrl_q.run0), .run1(ctrl_q.run1),
    .cascade(ctrl_q.cascade), .gate0(ctrl_q.gate0), .out_en(ctrl_q.out_en),
    .evt_in(evt_in), .uf0(uf0), .uf1(uf1), .tout(tout)
);

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick0 = 1'b1, tick1 = 1'b1, evt_in = 1'b0;
    logic       evt_alt = 1'b0;
    logic       uf0, uf1, tout, tout_n;
    int         checks = 0, errors = 0;

    always #10 clk = ~clk;

    cascade_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick0(tick0), .tick1(tick1), .evt_in(evt_in),
        .uf0(uf0), .uf1(uf1), .tout(tout), .tout_n(tout_n)
    );

    always @(negedge clk) if (evt_alt) evt_in <= ~evt_in;

    // {cascade, chsel, reload0, reload1, observe(0 uf0,1 uf1,2 tout), period}
    localparam logic [35:0] VECS [8] = '{
        {1'b0, 1'b0, 8'd3, 8'd0, 2'd0, 16'd4},
        {1'b0, 1'b0, 8'd0, 8'd9, 2'd1, 16'd10},
        {1'b0, 1'b0, 8'd0, 8'd0, 2'd0, 16'd1},
        {1'b1, 1'b0, 8'd2, 8'd3, 2'd1, 16'd12},
        {1'b1, 1'b1, 8'd0, 8'd4, 2'd1, 16'd5},
        {1'b0, 1'b0, 8'd3, 8'd50, 2'd2, 16'd8},
        {1'b0, 1'b1, 8'd20, 8'd4, 2'd2, 16'd10},
        {1'b1, 1'b0, 8'd1, 8'd2, 2'd2, 16'd12}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] cb(input logic r0, r1, cas, g0, g1, chs, oe);
        return {1'b0, oe, chs, g1, g0, cas, r1, r0};
    endfunction

    function automatic bit ev(input int sel, input logic prev);
        if (sel == 0) return uf0;
        if (sel == 1) return uf1;
        return tout && !prev;
    endfunction

    // cycles between two consecutive events, sampled at negedges
    task automatic measure(input int sel, output int n);
        logic prev;
        bit   got;
        prev = tout; got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk); got = ev(sel, prev); prev = tout;
        end
        n = 0; got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk); n++; got = ev(sel, prev); prev = tout;
        end
    endtask

    task automatic count_ev(input int sel, input int cyc, output int n);
        logic prev;
        prev = tout; n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (ev(sel, prev)) n++;
            prev = tout;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, k;
        logic t0;
        repeat (3) @(negedge clk);
        chk("R1 uf0", uf0, 0);
        chk("R1 uf1", uf1, 0);
        chk("R1 tout", tout, 0);
        chk("R1 tout_n", tout_n, 1);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            logic [35:0] e;
            string tag;
            e = VECS[v];
            tag = e[35] ? ((e[17:16] == 2) ? "R7" : "R5") : ((e[17:16] == 2) ? "R6" : "R2");
            wr(2'd2, 8'h00);
            wr(2'd0, e[33:26]);
            wr(2'd1, e[25:18]);
            wr(2'd2, cb(1, 1, e[35], 0, 0, e[34], 1));
            measure(int'(e[17:16]), n);
            chk(tag, n, int'(e[15:0]));
            chk("R10 tout_n", tout_n, !tout);
        end

        // R5: no low-byte strobe while chained
        wr(2'd2, 8'h00); wr(2'd0, 8'd1); wr(2'd1, 8'd1);
        wr(2'd2, cb(1, 0, 1, 0, 0, 0, 1));
        count_ev(0, 40, n);
        chk("R5 uf0 quiet", n, 0);

        // R3: stop then restart timing
        wr(2'd2, 8'h00); wr(2'd0, 8'd5);
        count_ev(0, 30, n);
        chk("R3 stopped", n, 0);
        wr(2'd2, cb(1, 0, 0, 0, 0, 0, 1));
        k = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); k++;
            if (uf0) break;
        end
        chk("R3 first strobe", k, 7);

        // R4: gated counting
        wr(2'd2, 8'h00); wr(2'd0, 8'd4);
        evt_in = 1'b0;
        wr(2'd2, cb(1, 0, 0, 1, 0, 0, 1));
        count_ev(0, 40, n);
        chk("R4 event low", n, 0);
        evt_alt = 1'b1;
        measure(0, n);
        chk("R4 alternating", n, 10);
        evt_alt = 1'b0;

        // R9: output disabled
        wr(2'd0, 8'd1);
        wr(2'd2, cb(1, 0, 0, 0, 0, 0, 0));
        count_ev(0, 20, k);
        t0 = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); if (tout) t0 = 1'b1;
        end
        chk("R9 held low", t0, 0);
        chk("R9 underflows seen", (k > 0), 1);

        // R8: switch channel without extra toggle
        wr(2'd2, 8'h00); wr(2'd0, 8'd3); wr(2'd1, 8'd200);
        wr(2'd2, cb(1, 1, 0, 0, 0, 0, 1));
        repeat (30) @(negedge clk);
        wr(2'd2, cb(1, 1, 0, 0, 0, 1, 1));
        t0 = tout;
        k = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); if (tout != t0) k++;
        end
        chk("R8 no switch toggle", k, 0);
        k = 0;
        for (int i = 0; i < 250; i++) begin
            @(negedge clk); if (tout != t0) begin k = 1; break; end
        end
        chk("R8 new channel toggles", k, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule